// File: doc/BRIEF.md
# Programmable Data-Enable Generator

This block produces a data-enable (DE) strobe for a pixel stream whose source carries only horizontal and vertical sync. Both sync inputs are brought to a common sense by a per-input polarity setting and reduced to single-cycle leading-edge pulses on the pixel clock. After each horizontal sync edge a pixel counter runs. After each vertical sync edge a line counter advances on every horizontal sync edge. DE is high where the pixel position lies inside a programmed horizontal window and the line position lies inside a programmed vertical window.

For interlaced material the vertical window of the second field is pushed down by a small programmable number of lines. Which field is current comes from one of two places. It is either an external field flag sampled at the vertical sync edge, or a built-in detector that looks at where in the line the vertical sync edge falls. A final select chooses between the generated strobe and an externally supplied DE. All settings are static inputs that are held steady while frames run.

Top module: `de_gen_top`

## Requirements
- R1: With horizontal delay H (0..255), DE rises in the cycle after the H-th clock edge that follows the edge which samples the horizontal sync edge, so H = 0 raises DE directly after that edge.
- R2: With vertical delay V (0..63), horizontal sync edges are numbered from the vertical sync edge, and a horizontal sync edge in the same cycle counts as number 1. The first active line is the one started by edge number V+1. No DE follows a vertical sync edge before the next horizontal sync edge arrives.
- R3: On an active line DE stays high for exactly W consecutive cycles, where W is the 12-bit width setting; a width setting of 0 gives 4096 cycles.
- R4: Exactly N consecutive lines are active per field, where N is the 12-bit height setting; a height setting of 0 gives 4096 lines. No DE appears on a line outside that range.
- R5: A polarity bit of 1 makes the rising edge of its sync input the active edge, and a polarity bit of 0 makes the falling edge the active edge. The two syncs have separate polarity bits.
- R6: The 3-bit field offset is added to the vertical delay only while the current field is the second field. The first field is never shifted.
- R7: With the field-source bit at 1, the field output takes the value of the field input sampled at the vertical sync edge (1 = second field).
- R8: With the field-source bit at 0, let L be the clock count between the two most recent horizontal sync edges and m the count from the last horizontal sync edge to the vertical sync edge. The field becomes second when L <= 4m < 3L and first otherwise. The field output changes only at vertical sync edges.
- R9: With the DE-select bit at 1, the DE output follows the external DE input in the same cycle. With the bit at 0, it shows the generated strobe.
- R10: During and after synchronous reset, with no sync activity, DE (select 0) and the field output stay low.
- R11: When the horizontal and vertical sync edges fall in the same cycle and detection is internal, the field becomes first. That horizontal edge is counted as line number 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync pin |
| vsync_in | input | 1 | Vertical sync pin |
| hs_pol | input | 1 | 1: horizontal sync active high |
| vs_pol | input | 1 | 1: vertical sync active high |
| h_delay | input | 8 | Pixel clocks from horizontal sync edge to first active pixel |
| v_delay | input | 6 | Lines from vertical sync edge to first active line |
| h_width | input | 12 | Active pixels per line (0 = 4096) |
| v_height | input | 12 | Active lines per field (0 = 4096) |
| field_ofs | input | 3 | Extra line delay for the second field |
| field_src_ext | input | 1 | 1: external field flag, 0: internal detection |
| field_in | input | 1 | External field flag, 1 = second field |
| de_sel | input | 1 | 1: pass external DE, 0: generated DE |
| ext_de_in | input | 1 | External digital DE |
| de_out | output | 1 | Data-enable output |
| field_second | output | 1 | Current field, 1 = second field |

## Verification
The critical overlap is a vertical sync edge that lands in the same cycle as a horizontal sync edge. The line counter must then restart and count that line at once, and the field detector must resolve to first field rather than read a mid-line position. Frames with the vertical edge placed at offset zero of a line provoke this, mixed at random with frames whose edge sits elsewhere in the line, including the exact quarter and three-quarter boundaries. The result is judged by counting DE cycles and the first DE position on every line against the window predicted from the line number, and by comparing the field output at the end of each frame.

// File: rtl/de_gen_pkg.sv
package de_gen_pkg;

    // Default field widths of the settings
    localparam int HDLY_W = 8;
    localparam int VDLY_W = 6;
    localparam int RES_W  = 12;
    localparam int OFS_W  = 3;
    // Counter width: room for largest delay plus largest window, with headroom
    localparam int CNT_W  = RES_W + 2;

    typedef enum logic {
        FIELD_FIRST  = 1'b0,
        FIELD_SECOND = 1'b1
    } field_t;

    // One-cycle leading-edge events from the two sync inputs
    typedef struct packed {
        logic hs;
        logic vs;
    } sync_ev_t;

endpackage

// File: rtl/de_sync_edge.sv
module de_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    input  logic active_high,
    output logic pulse
);
    logic norm;
    logic prev_q;

    assign norm = active_high ? sig_in : ~sig_in;

    // Reset to "already active" so a sync held active through reset makes no edge
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= norm;
    end

    assign pulse = norm & ~prev_q;

endmodule

// File: rtl/de_h_timing.sv
module de_h_timing #(
    parameter int HDLY_W = de_gen_pkg::HDLY_W,
    parameter int RES_W  = de_gen_pkg::RES_W,
    parameter int CNT_W  = RES_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hs_pulse,
    input  logic [HDLY_W-1:0] h_delay,
    input  logic [RES_W-1:0]  h_width,
    output logic [CNT_W-1:0]  hcnt,
    output logic              h_act
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] FULL    = CNT_W'(1) << RES_W;

    logic [CNT_W-1:0] beg_c;
    logic [CNT_W-1:0] wlen;
    logic [CNT_W-1:0] end_c;

    always_comb begin
        beg_c = CNT_W'(h_delay);
        wlen  = (h_width == '0) ? FULL : CNT_W'(h_width);
        end_c = beg_c + wlen;
    end

    // Pixel position since the last horizontal sync edge; parks at the top value
    always_ff @(posedge clk) begin
        if (rst)                  hcnt <= CNT_MAX;
        else if (hs_pulse)        hcnt <= '0;
        else if (hcnt != CNT_MAX) hcnt <= hcnt + CNT_W'(1);
    end

    assign h_act = (hcnt >= beg_c) && (hcnt < end_c);

    AST_H_LEAD: assert property (@(posedge clk) disable iff (rst)
        hs_pulse |=> (h_act == (h_delay == '0)));  // R1

endmodule

// File: rtl/de_v_timing.sv
module de_v_timing #(
    parameter int VDLY_W = de_gen_pkg::VDLY_W,
    parameter int RES_W  = de_gen_pkg::RES_W,
    parameter int OFS_W  = de_gen_pkg::OFS_W,
    parameter int CNT_W  = RES_W + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hs_pulse,
    input  logic               vs_pulse,
    input  de_gen_pkg::field_t field,
    input  logic [VDLY_W-1:0]  v_delay,
    input  logic [OFS_W-1:0]   field_ofs,
    input  logic [RES_W-1:0]   v_height,
    output logic               v_act
);
    import de_gen_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] FULL    = CNT_W'(1) << RES_W;

    logic [CNT_W-1:0] vcnt;
    logic [CNT_W-1:0] vstart;
    logic [CNT_W-1:0] hlen;
    logic [CNT_W-1:0] vstop;

    always_comb begin
        vstart = CNT_W'(v_delay) + ((field == FIELD_SECOND) ? CNT_W'(field_ofs) : '0);
        hlen   = (v_height == '0) ? FULL : CNT_W'(v_height);
        vstop  = vstart + hlen;
    end

    // Number of horizontal sync edges seen since the vertical sync edge
    always_ff @(posedge clk) begin
        if (rst)                              vcnt <= CNT_MAX;
        else if (vs_pulse)                    vcnt <= hs_pulse ? CNT_W'(1) : '0;
        else if (hs_pulse && vcnt != CNT_MAX) vcnt <= vcnt + CNT_W'(1);
    end

    assign v_act = (vcnt > vstart) && (vcnt <= vstop);

    AST_V_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
        vs_pulse && !hs_pulse |=> !v_act);  // R2

endmodule

// File: rtl/de_field_detect.sv
module de_field_detect #(
    parameter int CNT_W = de_gen_pkg::CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hs_pulse,
    input  logic               vs_pulse,
    input  logic [CNT_W-1:0]   hcnt,
    input  logic               src_ext,
    input  logic               field_in,
    output de_gen_pkg::field_t field_q
);
    import de_gen_pkg::*;

    localparam int            XW      = CNT_W + 3;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] len_q;
    logic             len_ok;
    logic [XW-1:0]    pos4;
    logic [XW-1:0]    len1;
    logic [XW-1:0]    len3;
    logic             mid_line;

    always_comb begin
        pos4     = (XW'(hcnt) + XW'(1)) << 2;
        len1     = XW'(len_q);
        len3     = len1 + (len1 << 1);
        mid_line = len_ok && !hs_pulse && (hcnt != CNT_MAX)
                   && (pos4 >= len1) && (pos4 < len3);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q   <= '0;
            len_ok  <= 1'b0;
            field_q <= FIELD_FIRST;
        end else begin
            if (hs_pulse && hcnt != CNT_MAX) begin
                len_q  <= hcnt + CNT_W'(1);
                len_ok <= 1'b1;
            end
            if (vs_pulse) begin
                if (src_ext) field_q <= field_in ? FIELD_SECOND : FIELD_FIRST;
                else         field_q <= mid_line ? FIELD_SECOND : FIELD_FIRST;
            end
        end
    end

    AST_FIELD_EXT: assert property (@(posedge clk) disable iff (rst)
        vs_pulse && src_ext |=> ((field_q == FIELD_SECOND) == $past(field_in)));  // R7

    AST_COINCIDE: assert property (@(posedge clk) disable iff (rst)
        vs_pulse && hs_pulse && !src_ext |=> (field_q == FIELD_FIRST));  // R11

endmodule

// File: rtl/de_gen_top.sv
module de_gen_top
    import de_gen_pkg::*;
#(
    parameter int HDLY_W_P = de_gen_pkg::HDLY_W,
    parameter int VDLY_W_P = de_gen_pkg::VDLY_W,
    parameter int RES_W_P  = de_gen_pkg::RES_W,
    parameter int OFS_W_P  = de_gen_pkg::OFS_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hsync_in,
    input  logic                vsync_in,
    input  logic                hs_pol,
    input  logic                vs_pol,
    input  logic [HDLY_W_P-1:0] h_delay,
    input  logic [VDLY_W_P-1:0] v_delay,
    input  logic [RES_W_P-1:0]  h_width,
    input  logic [RES_W_P-1:0]  v_height,
    input  logic [OFS_W_P-1:0]  field_ofs,
    input  logic                field_src_ext,
    input  logic                field_in,
    input  logic                de_sel,
    input  logic                ext_de_in,
    output logic                de_out,
    output logic                field_second
);
    localparam int CNT_W_L = RES_W_P + 2;
    localparam int NSYNC   = 2;

    logic [NSYNC-1:0] pins;
    logic [NSYNC-1:0] pols;
    logic [NSYNC-1:0] pulses;
    sync_ev_t         ev;

    assign pins = {vsync_in, hsync_in};
    assign pols = {vs_pol, hs_pol};

    for (genvar i = 0; i < NSYNC; i++) begin : g_sync
        de_sync_edge u_edge (
            .clk         (clk),
            .rst         (rst),
            .sig_in      (pins[i]),
            .active_high (pols[i]),
            .pulse       (pulses[i])
        );
    end

    assign ev.hs = pulses[0];
    assign ev.vs = pulses[1];

    logic [CNT_W_L-1:0] hcnt;
    logic               h_act;
    logic               v_act;
    field_t             field;
    logic               gen_de;

    de_h_timing #(.HDLY_W(HDLY_W_P), .RES_W(RES_W_P), .CNT_W(CNT_W_L)) u_h (
        .clk      (clk),
        .rst      (rst),
        .hs_pulse (ev.hs),
        .h_delay  (h_delay),
        .h_width  (h_width),
        .hcnt     (hcnt),
        .h_act    (h_act)
    );

    de_field_detect #(.CNT_W(CNT_W_L)) u_fld (
        .clk      (clk),
        .rst      (rst),
        .hs_pulse (ev.hs),
        .vs_pulse (ev.vs),
        .hcnt     (hcnt),
        .src_ext  (field_src_ext),
        .field_in (field_in),
        .field_q  (field)
    );

    de_v_timing #(.VDLY_W(VDLY_W_P), .RES_W(RES_W_P), .OFS_W(OFS_W_P), .CNT_W(CNT_W_L)) u_v (
        .clk       (clk),
        .rst       (rst),
        .hs_pulse  (ev.hs),
        .vs_pulse  (ev.vs),
        .field     (field),
        .v_delay   (v_delay),
        .field_ofs (field_ofs),
        .v_height  (v_height),
        .v_act     (v_act)
    );

    assign gen_de       = h_act & v_act;
    assign de_out       = de_sel ? ext_de_in : gen_de;
    assign field_second = (field == FIELD_SECOND);

    AST_DE_GATED: assert property (@(posedge clk) disable iff (rst)
        !de_sel && !v_act |-> !de_out);  // R4

    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ev.vs |=> $stable(field_second));  // R8

endmodule

// File: tb/tb_de_gen_top.sv
`timescale 1ns/1ps
module tb_de_gen_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hsync_in = 1'b0, vsync_in = 1'b0;
    logic        hs_pol = 1'b1, vs_pol = 1'b1;
    logic [7:0]  h_delay = '0;
    logic [5:0]  v_delay = '0;
    logic [11:0] h_width = 12'd1, v_height = 12'd1;
    logic [2:0]  field_ofs = '0;
    logic        field_src_ext = 1'b0, field_in = 1'b0;
    logic        de_sel = 1'b0, ext_de_in = 1'b0;
    logic        de_out, field_second;

    de_gen_top dut (
        .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .hs_pol(hs_pol), .vs_pol(vs_pol), .h_delay(h_delay), .v_delay(v_delay),
        .h_width(h_width), .v_height(v_height), .field_ofs(field_ofs),
        .field_src_ext(field_src_ext), .field_in(field_in), .de_sel(de_sel),
        .ext_de_in(ext_de_in), .de_out(de_out), .field_second(field_second)
    );

    always #10 clk = ~clk;  // 50 MHz

    int vectors = 0;
    int fails   = 0;

    // Per-frame reference parameters and per-line accumulators
    int    fr_P, fr_H, fr_W, fr_vst, fr_hts, fr_first, fr_cv;
    int    acc_cnt, acc_first;
    string fr_tag;

    function automatic bit exp_second(input bit src, input bit fin, input int cv, input int P);
        if (src) return fin;
        return (cv != 0) && (4 * cv >= P) && (4 * cv < 3 * P);
    endfunction

    function automatic int exp_line_cnt(input int L);
        int n;
        n = L - fr_first + 1;
        if (n >= fr_vst + 1 && n <= fr_vst + fr_hts) return fr_W;
        return 0;
    endfunction

    task automatic note(input int L, input int j);
        if (L == 1 && fr_cv > 0 && j < fr_cv) return;  // before the vertical edge
        if (de_out) begin
            if (acc_first < 0) acc_first = j;
            acc_cnt++;
        end
    endtask

    task automatic close_line(input int L);
        int e;
        if (L > 0) begin
            e = exp_line_cnt(L);
            vectors++;
            if (acc_cnt != e || (e > 0 && acc_first != fr_H)) begin
                fails++;
                $display("FAIL %s line %0d: got cnt=%0d first=%0d, expected cnt=%0d first=%0d",
                         fr_tag, L, acc_cnt, acc_first, e, (e > 0) ? fr_H : -1);
            end
        end
        acc_cnt   = 0;
        acc_first = -1;
    endtask

    task automatic run_frame(input int P, input int H, input int W, input int V, input int HT,
                             input int OFS, input bit src, input bit fin, input int cv,
                             input bit hp, input bit vp, input string tag);
        bit sec;
        int total, vs_left;
        sec      = exp_second(src, fin, cv, P);
        fr_P     = P;
        fr_H     = H;
        fr_W     = W;
        fr_hts   = (HT == 0) ? 4096 : HT;
        fr_vst   = V + (sec ? OFS : 0);
        fr_first = (cv == 0) ? 1 : 2;
        fr_cv    = cv;
        fr_tag   = tag;
        total    = 2 + fr_vst + fr_hts + 3;
        @(negedge clk);
        hs_pol = hp; vs_pol = vp;
        hsync_in = ~hp; vsync_in = ~vp;
        h_delay = H[7:0]; h_width = W[11:0];
        v_delay = V[5:0]; v_height = HT[11:0];
        field_ofs = OFS[2:0]; field_src_ext = src; field_in = fin;
        acc_cnt = 0; acc_first = -1; vs_left = 0;
        for (int L = 0; L < total; L++) begin
            for (int c = 0; c < P; c++) begin
                @(negedge clk);
                if (c == 0) begin
                    if (L > 0) begin
                        note(L - 1, P - 1);
                        close_line(L - 1);
                    end
                end else begin
                    note(L, c - 1);
                end
                if (L == 1 && c == cv) vs_left = 3;
                hsync_in = hp ? (c < 2) : !(c < 2);
                vsync_in = vp ? (vs_left > 0) : !(vs_left > 0);
                if (vs_left > 0) vs_left--;
            end
        end
        @(negedge clk);
        note(total - 1, P - 1);
        close_line(total - 1);
        vectors++;
        if (field_second != sec) begin
            fails++;
            $display("FAIL %s field: got %0d, expected %0d", src ? "R7" : "R8 R11",
                     field_second, sec);
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R10: quiet during and after reset
        repeat (3) begin
            @(negedge clk);
            vectors++;
            if (de_out !== 1'b0 || field_second !== 1'b0) begin
                fails++;
                $display("FAIL R10 in reset: got de=%0d field=%0d, expected 0 0", de_out, field_second);
            end
        end
        @(negedge clk); rst = 1'b0;
        repeat (5) begin
            @(negedge clk);
            vectors++;
            if (de_out !== 1'b0 || field_second !== 1'b0) begin
                fails++;
                $display("FAIL R10 after reset: got de=%0d field=%0d, expected 0 0", de_out, field_second);
            end
        end

        // R9: external DE pass-through
        de_sel = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            ext_de_in = 1'($urandom % 2);
            #1;
            vectors++;
            if (de_out !== ext_de_in) begin
                fails++;
                $display("FAIL R9: got de=%0d, expected %0d", de_out, ext_de_in);
            end
        end
        de_sel = 1'b0; ext_de_in = 1'b0;

        // Directed corners
        run_frame(20, 0, 4, 0, 2, 0, 1'b0, 1'b0, 0, 1'b1, 1'b1, "R1 R2 R11");
        run_frame(40, 3, 10, 2, 3, 3, 1'b0, 1'b0, 20, 1'b1, 1'b0, "R5 R6 R8");
        run_frame(40, 3, 10, 2, 3, 3, 1'b0, 1'b0, 10, 1'b0, 1'b1, "R5 R6 R8 quarter");
        run_frame(40, 3, 10, 2, 3, 3, 1'b0, 1'b0, 9, 1'b1, 1'b1, "R6 R8 early");
        run_frame(40, 3, 10, 2, 3, 3, 1'b0, 1'b0, 29, 1'b1, 1'b1, "R6 R8 late-in");
        run_frame(40, 3, 10, 2, 3, 3, 1'b0, 1'b0, 30, 1'b1, 1'b1, "R6 R8 three-quarter");
        run_frame(16, 3, 5, 63, 3, 7, 1'b1, 1'b1, 5, 1'b0, 1'b0, "R2 R6 R7 max-delay");
        run_frame(16, 3, 5, 1, 3, 7, 1'b1, 1'b0, 5, 1'b1, 1'b1, "R6 R7 first");
        run_frame(300, 255, 40, 1, 2, 0, 1'b1, 1'b0, 0, 1'b1, 1'b1, "R1 max-delay");
        run_frame(4200, 5, 4096, 1, 2, 0, 1'b1, 1'b0, 0, 1'b1, 1'b1, "R3 width-zero");
        run_frame(4, 0, 1, 0, 0, 0, 1'b1, 1'b0, 0, 1'b1, 1'b1, "R4 height-zero");

        // Random frames
        for (int f = 0; f < 24; f++) begin
            int P, H, W, V, HT, OFS, cv;
            bit src, fin, hp, vp;
            P   = 30 + int'($urandom % 61);
            H   = int'($urandom % 20);
            W   = 1 + int'($urandom % (P - H));
            V   = int'($urandom % 8);
            HT  = 1 + int'($urandom % 6);
            OFS = int'($urandom % 8);
            src = 1'($urandom % 2);
            fin = 1'($urandom % 2);
            hp  = 1'($urandom % 2);
            vp  = 1'($urandom % 2);
            cv  = ($urandom % 4 == 0) ? 0 : int'($urandom % P);
            run_frame(P, H, W, V, HT, OFS, src, fin, cv, hp, vp, "R1 R2 R3 R4 R5 R6 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule